// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is a single-cycle datapath that executes one packed 10-bit instruction on every rising clock edge. It keeps four 4-bit registers behind two combinational read ports and one write port whose enable is permanently asserted. The two read values feed a 4-bit ALU built on a carry-lookahead adder. The ALU performs and, or, add, subtract and signed set-less-than.

On each edge the destination register takes one of two values. With the load bit set it takes the external load value. Otherwise it takes the ALU result. Because the write port is always enabled, every instruction writes its destination, and a plain register copy must be encoded as an ALU operation.

Both read values and the ALU result are driven out of the block. A routine can therefore be followed entirely from the ports, one instruction per cycle.

Top module: `regalu_datapath`

## Requirements
- R1: The instruction layout is fixed: bit 9 is the load flag, bits 8..6 the ALU op, bits 5..4 read address A, bits 3..2 read address B, and bits 1..0 the destination address.
- R2: With the load flag at 1, the rising edge writes `load_data` into the destination register. The op and both read-address fields have no effect on what is written.
- R3: With the load flag at 0, the rising edge writes the ALU result into the destination register.
- R4: Every rising edge outside reset writes exactly one register, the destination. The other three keep their values.
- R5: `rd_a_data` and `rd_b_data` show the registers selected by read addresses A and B combinationally, including a value written on the previous edge.
- R6: Op 000 gives A and B, op 001 gives A or B, and op 010 gives A plus B modulo 16.
- R7: Op 110 gives A minus B modulo 16, formed as A plus the complement of B plus a carry-in of 1.
- R8: Op 111 gives 1 in bit 0 when A is less than B as signed 4-bit numbers, and 0 otherwise. Bits 3..1 are 0.
- R9: Ops 011, 100 and 101 give a result of 0.
- R10: A rising edge with `rst` high clears all four registers to 0.
- R11: After reset, the routine below leaves r0 = 7, r1 = 3, r2 = 1 and r3 = 0. The routine loads 1, 3 and 2 into r0, r1 and r2, then runs r3 = r1 + r2, r2 = r3 − r0, r0 = r1 | r2, r3 = r2 & r1 and r2 = slt(r1, r0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all register writes happen on its rising edge |
| rst | input | 1 | Synchronous active-high reset that clears the registers |
| instr | input | 10 | Packed instruction: load, op, read A, read B, destination |
| load_data | input | 4 | Value written when the load flag is set |
| rd_a_data | output | 4 | Register selected by read address A (operand A) |
| rd_b_data | output | 4 | Register selected by read address B (operand B) |
| alu_result | output | 4 | ALU result for the current op and operands |

## Verification
A wrong register value cannot stay hidden for long. The next instruction that names that register as an operand shows the bad value on a read port in the same cycle, and the ALU result moves with it. A write to the wrong register has two visible effects. The intended register keeps its stale value, and a bystander register changes. Both show up when any later instruction reads either register. For this reason the reference model compares both read ports and the result on every cycle, and the bench reads out the whole register file at each checkpoint so that a corrupted register is reported within a few cycles.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;

  localparam int OP_W = 3;

  // ALU op codes; bit 2 selects operand-B inversion with carry-in of 1.
  typedef enum logic [OP_W-1:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  // Signed less-than from a subtraction: sign corrected by overflow.
  function automatic logic lt_from_diff(input logic sign_bit, input logic ovf);
    return sign_bit ^ ovf;
  endfunction

  // Signed overflow from the two top carries of an adder.
  function automatic logic ovf_from_carries(input logic c_top, input logic c_prev);
    return c_top ^ c_prev;
  endfunction

endpackage

// File: rtl/dp_cla_adder.sv
`timescale 1ns/1ps
module dp_cla_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;
  logic         term;
  logic         chain;

  assign gen  = a & b;
  assign prop = a ^ b;

  // Every carry is flattened from the generate/propagate terms
  // instead of rippling through the previous carry.
  always_comb begin
    carry[0] = cin;
    term     = 1'b0;
    chain    = 1'b0;
    for (int i = 0; i < W; i++) begin
      term  = gen[i];
      chain = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        term  = term | (chain & gen[j]);
        chain = chain & prop[j];
      end
      carry[i+1] = term | (chain & cin);
    end
  end

  assign sum  = prop ^ carry[W-1:0];
  assign cout = carry[W];
  assign ovf  = dp_pkg::ovf_from_carries(carry[W], carry[W-1]);

endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0]          opnd_a,
  input  logic [W-1:0]          opnd_b,
  input  logic [dp_pkg::OP_W-1:0] op,
  output logic [W-1:0]          result
);
  import dp_pkg::*;

  logic         b_invert;
  logic [W-1:0] b_eff;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;
  logic         less_bit;

  assign b_invert = op[OP_W-1];
  assign b_eff    = b_invert ? ~opnd_b : opnd_b;

  dp_cla_adder #(.W(W)) u_adder (
    .a    (opnd_a),
    .b    (b_eff),
    .cin  (b_invert),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  assign less_bit = lt_from_diff(add_sum[W-1], add_ovf);

  always_comb begin
    case (op)
      OP_AND:  result = opnd_a & opnd_b;
      OP_OR:   result = opnd_a | opnd_b;
      OP_ADD:  result = add_sum;
      OP_SUB:  result = add_sum;
      OP_SLT:  result = {{(W-1){1'b0}}, less_bit};
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/dp_regfile.sv
`timescale 1ns/1ps
module dp_regfile #(
  parameter int W  = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b
);
  localparam int NREG = 1 << AW;

  logic [W-1:0]    regs [NREG];
  logic [NREG-1:0] wr_sel;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_sel[i] = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (rst)            regs[i] <= '0;
      else if (wr_sel[i]) regs[i] <= wr_data;
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
      (!rst && wr_sel[i]) |=> (regs[i] == $past(wr_data)));

    assert_bystander_stable_R4: assert property (@(posedge clk) disable iff (rst)
      (!rst && !wr_sel[i]) |=> $stable(regs[i]));
  end

  assign rd_data_a = regs[rd_addr_a];
  assign rd_data_b = regs[rd_addr_b];

  assert_single_write_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

endmodule

// File: rtl/regalu_datapath.sv
`timescale 1ns/1ps
module regalu_datapath #(
  parameter int DATA_W = 4,
  parameter int ADDR_W = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [1+dp_pkg::OP_W+3*ADDR_W-1:0]  instr,
  input  logic [DATA_W-1:0]                   load_data,
  output logic [DATA_W-1:0]                   rd_a_data,
  output logic [DATA_W-1:0]                   rd_b_data,
  output logic [DATA_W-1:0]                   alu_result
);
  import dp_pkg::*;

  localparam int INSTR_W  = 1 + OP_W + 3 * ADDR_W;
  localparam int LOAD_POS = INSTR_W - 1;
  localparam int OP_TOP   = LOAD_POS - 1;
  localparam int RA_TOP   = 3 * ADDR_W - 1;
  localparam int RB_TOP   = 2 * ADDR_W - 1;

  // Field decode: load, op, read A, read B, destination (MSB first).
  logic              f_load;
  logic [OP_W-1:0]   f_op;
  logic [ADDR_W-1:0] f_ra;
  logic [ADDR_W-1:0] f_rb;
  logic [ADDR_W-1:0] f_rc;
  logic [DATA_W-1:0] wr_value;

  assign f_load = instr[LOAD_POS];
  assign f_op   = instr[OP_TOP -: OP_W];
  assign f_ra   = instr[RA_TOP -: ADDR_W];
  assign f_rb   = instr[RB_TOP -: ADDR_W];
  assign f_rc   = instr[ADDR_W-1:0];

  dp_regfile #(.W(DATA_W), .AW(ADDR_W)) u_rf (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (1'b1),
    .wr_addr   (f_rc),
    .wr_data   (wr_value),
    .rd_addr_a (f_ra),
    .rd_addr_b (f_rb),
    .rd_data_a (rd_a_data),
    .rd_data_b (rd_b_data)
  );

  dp_alu #(.W(DATA_W)) u_alu (
    .opnd_a (rd_a_data),
    .opnd_b (rd_b_data),
    .op     (f_op),
    .result (alu_result)
  );

  assign wr_value = f_load ? load_data : alu_result;

  assert_add_wraps_R6: assert property (@(posedge clk) disable iff (rst)
    (f_op == OP_ADD) |-> (alu_result == DATA_W'(rd_a_data + rd_b_data)));

  assert_sub_diff_R7: assert property (@(posedge clk) disable iff (rst)
    (f_op == OP_SUB) |-> (alu_result == DATA_W'(rd_a_data - rd_b_data)));

  assert_slt_signed_R8: assert property (@(posedge clk) disable iff (rst)
    (f_op == OP_SLT) |-> (alu_result ==
      (($signed(rd_a_data) < $signed(rd_b_data)) ? DATA_W'(1) : DATA_W'(0))));

  assert_undef_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (f_op == 3'b011 || f_op == 3'b100 || f_op == 3'b101) |-> (alu_result == '0));

endmodule

// File: tb/test_regalu_datapath.sv
`timescale 1ns/1ps
module test_regalu_datapath;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] instr = '0;
  logic [3:0] load_data = '0;
  logic [3:0] rd_a_data;
  logic [3:0] rd_b_data;
  logic [3:0] alu_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int model [4];

  always #10 clk = ~clk;

  regalu_datapath i_regalu_datapath (
    .clk        (clk),
    .rst        (rst),
    .instr      (instr),
    .load_data  (load_data),
    .rd_a_data  (rd_a_data),
    .rd_b_data  (rd_b_data),
    .alu_result (alu_result)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int sgn4(input int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  // Expected ALU value for op code o on operand values a, b.
  function automatic int ref_alu(input int o, input int a, input int b);
    case (o)
      0: return a & b;
      1: return a | b;
      2: return (a + b) % 16;
      6: return (a - b + 16) % 16;
      7: return (sgn4(a) < sgn4(b)) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string op_tag(input int o);
    case (o)
      0, 1, 2: return "R6";
      6:       return "R7";
      7:       return "R8";
      default: return "R9";
    endcase
  endfunction

  // One instruction: drive at falling edge, compare, update model on rising edge.
  task automatic step(input int ld, input int o, input int ra, input int rb,
                      input int rc, input int data, input string rtag);
    int ea, eb, ey;
    @(negedge clk);
    instr     = {1'(ld), 3'(o), 2'(ra), 2'(rb), 2'(rc)};   // R1 field layout
    load_data = 4'(data);
    #2;
    if (!rst) begin
      ea = model[ra];
      eb = model[rb];
      ey = ref_alu(o, ea, eb);
      check(rtag, "rd_a_data", int'(rd_a_data), ea);
      check(rtag, "rd_b_data", int'(rd_b_data), eb);
      check(op_tag(o), "alu_result", int'(alu_result), ey);
    end else begin
      ey = 0;
    end
    @(posedge clk);
    if (rst) begin
      foreach (model[k]) model[k] = 0;
    end else begin
      model[rc] = (ld != 0) ? data : ey;
    end
  endtask

  // Reads all four registers through the read ports; rewrites r0 with its own value.
  task automatic read_all(input string tag, input int e0, input int e1, input int e2, input int e3);
    @(negedge clk);
    instr = {1'b1, 3'b000, 2'd0, 2'd1, 2'd0};
    load_data = 4'(model[0]);
    #2;
    check(tag, "r0", int'(rd_a_data), e0);
    check(tag, "r1", int'(rd_b_data), e1);
    instr = {1'b1, 3'b000, 2'd2, 2'd3, 2'd0};
    #2;
    check(tag, "r2", int'(rd_a_data), e2);
    check(tag, "r3", int'(rd_b_data), e3);
  endtask

  initial begin
    foreach (model[k]) model[k] = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    read_all("R10", 0, 0, 0, 0);

    // Routine: loads then add, sub, or, and, slt.
    step(1, 7, 3, 2, 0, 1, "R2");   // load ignores op/ra/rb fields
    step(1, 5, 1, 0, 1, 3, "R2");
    step(1, 0, 2, 3, 2, 2, "R2");
    step(0, 2, 1, 2, 3, 0, "R5");   // r3 = r1 + r2
    step(0, 6, 3, 0, 2, 0, "R5");   // r2 = r3 - r0 (reads fresh r3)
    step(0, 1, 1, 2, 0, 0, "R5");   // r0 = r1 | r2
    step(0, 0, 2, 1, 3, 0, "R5");   // r3 = r2 & r1
    step(0, 7, 1, 0, 2, 0, "R5");   // r2 = slt(r1, r0)
    read_all("R11", 7, 3, 1, 0);

    // Exhaustive operand and op sweep; loads carry junk op/read fields.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int o = 0; o < 8; o++) begin
          step(1, o, b % 4, a % 4, 1, a, "R2");
          step(1, 7 - o, 3, 0, 2, b, "R2");
          step(0, o, 1, 2, 3, 0, "R5");
          step(0, 3, 3, 0, 0, 0, "R3");   // read back the result written to r3
        end
      end
      read_all("R4", model[0], model[1], model[2], model[3]);
    end

    // Mid-run reset clears everything.
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    foreach (model[k]) model[k] = 0;
    @(negedge clk);
    rst = 1'b0;
    read_all("R10", 0, 0, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule